// File: doc/BRIEF.md
# Shared Chunk Pool Packet Queue

This block is the central packet store of an 8-port packet switch. Any input port may write 64-bit chunks into one common RAM of 128 chunks. Each chunk carries a destination port and an end-of-packet flag. The block takes free chunk slots from a free list. It links the chunks of a packet as they arrive. It hangs the complete packet on the queue of its output only once the final chunk has been stored.

Output ports ask for chunks. They receive them in packet order, with the output index and an end-of-packet flag. Each chunk that is read goes back to the free list.

Two least-recently-granted arbiters pick one writing input and one reading output in each cycle. A write and a read may happen in the same cycle. The free-chunk count is an output, so that upstream flow control can throttle senders.

Top module: `shared_chunk_queue`

## Requirements
- R1: After reset, `free_cnt` is 128, `rd_valid` is 0, and no read is granted even when every output requests.
- R2: `wr_gnt` is one-hot or zero, is set only for a requesting input, and is zero whenever `free_cnt` is 0.
- R3: At each clock edge, `free_cnt` falls by 1 for a granted write and rises by 1 for a granted read. It is unchanged when both occur, and it never exceeds 128.
- R4: No chunk of a packet can be read before the chunk flagged end-of-packet has been written. Until then its output gets no read grant on its behalf.
- R5: Each output receives its chunks in write order within a packet, and its packets in order of completion. The data is unchanged, and `rd_last` is 1 exactly on the final chunk of each packet.
- R6: A packet goes to the `wr_dest` given with its first chunk. The `wr_dest` presented with later chunks of the same packet has no effect.
- R7: Among the inputs that request while a chunk is free, the write grant goes to the input granted least recently. After reset, lower input index ranks as older.
- R8: Among the outputs that request and hold a complete packet, the read grant goes to the output granted least recently. After reset, lower output index ranks as older.
- R9: A read granted in one cycle presents `rd_valid`=1, `rd_port`, `rd_data` and `rd_last` after the next clock edge. Otherwise `rd_valid` is 0 after that edge.
- R10: When the pool is full, a chunk freed by a read in one cycle can be granted to a writer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 8 | Per-input chunk write request |
| wr_dest | input | 24 | Per-input destination output, 3 bits per input (input p at bits 3p+2:3p) |
| wr_eop | input | 8 | Per-input end-of-packet flag for the offered chunk |
| wr_data | input | 512 | Per-input chunk data, 64 bits per input (input p at bits 64p+63:64p) |
| wr_gnt | output | 8 | Write accepted at this clock edge (combinational) |
| rd_req | input | 8 | Per-output chunk read request |
| rd_gnt | output | 8 | Read accepted at this clock edge (combinational) |
| rd_valid | output | 1 | Read result is valid |
| rd_port | output | 3 | Output that the read result belongs to |
| rd_data | output | 64 | Chunk data read |
| rd_last | output | 1 | Chunk read is the last of its packet |
| free_cnt | output | 8 | Number of free chunks |

## Verification
Random traffic runs in several mixes: write-heavy, read-heavy, and balanced. The write-heavy mix drives the pool to empty, which separates refusal of writes from ordinary arbitration losses. Many packets interleave across inputs, and later chunks carry random destinations. This exposes any wrong chaining, early visibility of a packet, or use of the wrong destination.

A directed fill-and-release sequence shows that a freed chunk can be granted on the very next cycle. A cycle in which all inputs and outputs request at once shows whether least-recently-granted order is kept or whether a fixed priority takes over.

// File: rtl/shared_chunk_queue.sv
module lru_arb #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         any
);
  logic [W-1:0] ord [N];
  logic [W-1:0] pos;

  always_comb begin
    any = 1'b0;
    pos = '0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (req[ord[k]]) begin
        any = 1'b1;
        pos = W'(k);
        idx = ord[k];
      end
  end

  assign gnt = any ? (N'(1) << idx) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < N; k++) ord[k] <= W'(k);
    end else if (any) begin
      for (int k = 0; k < N - 1; k++)
        if (W'(k) >= pos) ord[k] <= ord[k+1];
      ord[N-1] <= idx;
    end
endmodule

module shared_chunk_queue #(
  parameter int NPORT  = 8,
  parameter int NCHUNK = 128,
  parameter int DW     = 64,
  localparam int PW = $clog2(NPORT),
  localparam int CW = $clog2(NCHUNK),
  localparam int FW = $clog2(NCHUNK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    wr_req,
  input  logic [NPORT*PW-1:0] wr_dest,
  input  logic [NPORT-1:0]    wr_eop,
  input  logic [NPORT*DW-1:0] wr_data,
  output logic [NPORT-1:0]    wr_gnt,
  input  logic [NPORT-1:0]    rd_req,
  output logic [NPORT-1:0]    rd_gnt,
  output logic                rd_valid,
  output logic [PW-1:0]       rd_port,
  output logic [DW-1:0]       rd_data,
  output logic                rd_last,
  output logic [FW-1:0]       free_cnt
);
  logic [DW-1:0]     mem  [NCHUNK];
  logic [CW-1:0]     link [NCHUNK];
  logic [CW-1:0]     fl   [NCHUNK];
  logic [NCHUNK-1:0] last;
  logic [CW-1:0]     fl_rd, fl_wr;

  logic [NPORT-1:0]  open, qne;
  logic [CW-1:0]     ph [NPORT];
  logic [CW-1:0]     pt [NPORT];
  logic [PW-1:0]     pd [NPORT];
  logic [CW-1:0]     qh [NPORT];
  logic [CW-1:0]     qt [NPORT];

  logic          wr_any, rd_any;
  logic [PW-1:0] wsel, rsel;

  lru_arb #(.N(NPORT)) u_warb (
    .clk(clk), .rst_n(rst_n), .req(wr_req & {NPORT{free_cnt != '0}}),
    .gnt(wr_gnt), .idx(wsel), .any(wr_any));

  lru_arb #(.N(NPORT)) u_rarb (
    .clk(clk), .rst_n(rst_n), .req(rd_req & qne),
    .gnt(rd_gnt), .idx(rsel), .any(rd_any));

  wire [CW-1:0]    wch   = fl[fl_rd];
  wire [CW-1:0]    rch   = qh[rsel];
  wire             w_eop = wr_eop[wsel];
  wire [PW-1:0]    wdst  = open[wsel] ? pd[wsel] : wr_dest[wsel*PW +: PW];
  wire [CW-1:0]    ahead = open[wsel] ? ph[wsel] : wch;
  wire [NPORT-1:0] app_v = (wr_any && w_eop) ? (NPORT'(1) << wdst) : '0;

  always_ff @(posedge clk) begin
    if (wr_any) mem[wch] <= wr_data[wsel*DW +: DW];
    if (rd_any) rd_data <= mem[rch];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fl_rd    <= '0;
      fl_wr    <= '0;
      free_cnt <= FW'(NCHUNK);
      open     <= '0;
      qne      <= '0;
      last     <= '0;
      rd_valid <= 1'b0;
      rd_port  <= '0;
      rd_last  <= 1'b0;
      for (int i = 0; i < NCHUNK; i++) begin
        fl[i]   <= CW'(i);
        link[i] <= '0;
      end
      for (int p = 0; p < NPORT; p++) begin
        ph[p] <= '0; pt[p] <= '0; pd[p] <= '0;
        qh[p] <= '0; qt[p] <= '0;
      end
    end else begin
      rd_valid <= rd_any;
      free_cnt <= free_cnt - FW'(wr_any) + FW'(rd_any);
      if (rd_any) begin
        rd_port   <= rsel;
        rd_last   <= last[rch];
        fl[fl_wr] <= rch;
        fl_wr     <= fl_wr + 1'b1;
      end
      if (wr_any) begin
        fl_rd     <= fl_rd + 1'b1;
        last[wch] <= w_eop;
        if (open[wsel]) link[pt[wsel]] <= wch;
        if (w_eop) open[wsel] <= 1'b0;
        else begin
          open[wsel] <= 1'b1;
          pt[wsel]   <= wch;
          if (!open[wsel]) begin
            ph[wsel] <= wch;
            pd[wsel] <= wr_dest[wsel*PW +: PW];
          end
        end
      end
      for (int o = 0; o < NPORT; o++) begin
        if (app_v[o]) begin
          if (qne[o]) link[qt[o]] <= ahead;
          if (!qne[o] || (rd_gnt[o] && qh[o] == qt[o])) qh[o] <= ahead;
          else if (rd_gnt[o]) qh[o] <= link[qh[o]];
          qt[o]  <= wch;
          qne[o] <= 1'b1;
        end else if (rd_gnt[o]) begin
          if (qh[o] == qt[o]) qne[o] <= 1'b0;
          else qh[o] <= link[qh[o]];
        end
      end
    end
endmodule

// File: rtl/shared_chunk_queue_chk.sv
module shared_chunk_queue_chk #(
  parameter int NPORT  = 8,
  parameter int NCHUNK = 128,
  localparam int FW = $clog2(NCHUNK + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] wr_req,
  input logic [NPORT-1:0] wr_gnt,
  input logic [NPORT-1:0] rd_req,
  input logic [NPORT-1:0] rd_gnt,
  input logic             rd_valid,
  input logic [FW-1:0]    free_cnt
);
  AST_WR_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_gnt)); // R2
  AST_WR_ONLY_REQ:  assert property (@(posedge clk) disable iff (!rst_n) (wr_gnt & ~wr_req) == '0); // R2
  AST_NO_WR_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) free_cnt == '0 |-> wr_gnt == '0); // R2
  AST_FREE_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) free_cnt <= FW'(NCHUNK)); // R3
  AST_FREE_COUNT:   assert property (@(posedge clk) disable iff (!rst_n)
                      $past(rst_n) |-> free_cnt == $past(free_cnt) - FW'($past(|wr_gnt)) + FW'($past(|rd_gnt))); // R3
  AST_RD_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_gnt) && (rd_gnt & ~rd_req) == '0); // R8
  AST_RD_VALID:     assert property (@(posedge clk) disable iff (!rst_n) |rd_gnt |=> rd_valid); // R9
  AST_RD_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) !(|rd_gnt) |=> !rd_valid); // R9
endmodule

bind shared_chunk_queue shared_chunk_queue_chk #(.NPORT(NPORT), .NCHUNK(NCHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_gnt(wr_gnt),
  .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_valid(rd_valid), .free_cnt(free_cnt));

// File: tb/sim_shared_chunk_queue.sv
`timescale 1ns/1ps
module sim_shared_chunk_queue;
  localparam int N = 8;
  localparam int C = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] wr_req = '0, wr_eop = '0, rd_req = '0;
  logic [N*3-1:0] wr_dest = '0;
  logic [N*64-1:0] wr_data = '0;
  logic [N-1:0] wr_gnt, rd_gnt;
  logic rd_valid, rd_last;
  logic [2:0] rd_port;
  logic [63:0] rd_data;
  logic [7:0] free_cnt;

  shared_chunk_queue u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int wo[N], ro[N];
  int fcnt;
  bit popen[N];
  int pdest[N];
  logic [64:0] pq[N][$];
  logic [64:0] oq[N][$];
  logic [N-1:0] last_wg, last_rg;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(input int o[N], input logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[o[k]]) return o[k];
    return -1;
  endfunction

  task automatic promote(inout int o[N], input int g);
    int k = 0;
    while (o[k] != g) k++;
    for (int j = k; j < N - 1; j++) o[j] = o[j+1];
    o[N-1] = g;
  endtask

  task automatic drive(input logic [N-1:0] wq, input logic [N-1:0] we,
                       input logic [N*3-1:0] wd, input logic [N-1:0] rq);
    logic [N-1:0] weff, reff, ew, er;
    int wg, rg;
    logic [64:0] e;
    @(negedge clk);
    wr_req = wq; wr_eop = we; wr_dest = wd; rd_req = rq;
    for (int p = 0; p < N; p++) wr_data[p*64 +: 64] = {$urandom, $urandom};
    #1;
    weff = (fcnt != 0) ? wq : '0;
    for (int o = 0; o < N; o++) reff[o] = rq[o] && (oq[o].size() != 0);
    wg = pick(wo, weff);
    rg = pick(ro, reff);
    ew = (wg < 0) ? '0 : (N'(1) << wg);
    er = (rg < 0) ? '0 : (N'(1) << rg);
    chk(wr_gnt == ew, "R2 R7 wr_gnt", 64'(wr_gnt), 64'(ew));
    chk(rd_gnt == er, "R4 R8 rd_gnt", 64'(rd_gnt), 64'(er));
    chk(free_cnt == 8'(fcnt), "R3 free_cnt", 64'(free_cnt), 64'(fcnt));
    last_wg = wr_gnt; last_rg = rd_gnt;
    @(posedge clk); #1;
    if (rg >= 0) begin
      e = oq[rg].pop_front();
      promote(ro, rg);
      fcnt++;
      chk(rd_valid === 1'b1, "R9 rd_valid", 64'(rd_valid), 1);
      chk(rd_port == 3'(rg), "R9 rd_port", 64'(rd_port), 64'(rg));
      chk(rd_data == e[63:0], "R5 rd_data", rd_data, e[63:0]);
      chk(rd_last == e[64], "R5 rd_last", 64'(rd_last), 64'(e[64]));
    end else
      chk(rd_valid === 1'b0, "R9 rd_valid idle", 64'(rd_valid), 0);
    if (wg >= 0) begin
      promote(wo, wg);
      fcnt--;
      if (!popen[wg]) begin popen[wg] = 1; pdest[wg] = int'(wd[wg*3 +: 3]); end
      pq[wg].push_back({we[wg], wr_data[wg*64 +: 64]});
      if (we[wg]) begin
        while (pq[wg].size() != 0) oq[pdest[wg]].push_back(pq[wg].pop_front());
        popen[wg] = 0;
      end
    end
  endtask

  task automatic rnd(input int cycles, input int wp, input int rp, input int ep);
    logic [N-1:0] wq, we, rq;
    logic [N*3-1:0] wd;
    for (int c = 0; c < cycles; c++) begin
      for (int p = 0; p < N; p++) begin
        wq[p] = ($urandom % 100) < wp;
        we[p] = ($urandom % 100) < ep;
        rq[p] = ($urandom % 100) < rp;
        wd[p*3 +: 3] = 3'($urandom);
      end
      drive(wq, we, wd, rq);
    end
  endtask

  task automatic drain();
    logic [N-1:0] op;
    for (int c = 0; c < 300; c++) begin
      for (int p = 0; p < N; p++) op[p] = popen[p];
      drive(op, '1, 24'($urandom), '1);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin wo[k] = k; ro[k] = k; popen[k] = 0; end
    fcnt = C;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    rd_req = '1;
    #1;
    chk(free_cnt == 8'd128, "R1 free_cnt", 64'(free_cnt), 128);
    chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 0);
    chk(rd_gnt == '0, "R1 rd_gnt", 64'(rd_gnt), 0);

    // R4 and R6: three-chunk packet from input 0, later chunks point elsewhere
    drive(8'h01, 8'h00, 24'h000002, 8'hFF);
    drive(8'h01, 8'h00, 24'h000005, 8'hFF);
    chk(last_rg == '0, "R4 no read before end", 64'(last_rg), 0);
    drive(8'h01, 8'h01, 24'h000007, 8'hFF);
    chk(last_rg == '0, "R4 no read on end cycle", 64'(last_rg), 0);
    drive(8'h00, 8'h00, 24'h0, 8'hFF);
    chk(last_rg == 8'h04, "R6 first-chunk destination", 64'(last_rg), 64'h04);
    drive(8'h00, 8'h00, 24'h0, 8'hFF);
    drive(8'h00, 8'h00, 24'h0, 8'hFF);
    drive(8'h00, 8'h00, 24'h0, 8'hFF);

    // R7: all inputs at once get distinct grants over eight cycles
    begin
      logic [N-1:0] seen = '0;
      for (int c = 0; c < N; c++) begin
        drive('1, '1, 24'($urandom), '0);
        seen |= last_wg;
      end
      chk(seen == '1, "R7 every input served", 64'(seen), 64'hFF);
    end
    drain();

    rnd(1500, 70, 20, 25);
    rnd(1500, 30, 80, 25);
    rnd(1500, 50, 50, 40);
    drain();

    // R10: fill the pool, then release one chunk
    for (int c = 0; c < C + 4; c++) drive('1, '1, 24'($urandom), '0);
    chk(free_cnt == 8'd0, "R10 pool full", 64'(free_cnt), 0);
    drive('1, '1, 24'($urandom), '1);
    chk(last_wg == '0, "R10 write refused when full", 64'(last_wg), 0);
    chk(last_rg != '0, "R10 read while full", 64'(last_rg), 1);
    drive('1, '1, 24'($urandom), '0);
    chk(last_wg != '0, "R10 freed chunk reused next cycle", 64'(last_wg), 1);
    drain();
    chk(free_cnt == 8'd128, "R3 pool fully returned", 64'(free_cnt), 128);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule